// File: doc/BRIEF.md
# Inbound Address Translation Window

This block maps addresses that arrive from an external bus into the local memory space. Software programs two registers. The translation register holds the local base address and a 5-bit size code. The inbound base register holds the external address that the window matches against. The size code N sets the window to 2^(N+1) bytes. That one size governs both matching and translation.

When a valid incoming address falls inside the window, the block registers a hit. It also forms the translated address. The offset bits below the window size come from the incoming address, and the bits above come from the translation base. Base bits below the window granularity are ignored on both sides. The code zero disables the window, and the codes outside the legal range behave the same way. Translated addresses always lie in the lower half of the 32-bit local space.

Top module: `itw_top`

## Requirements
- R1: After reset, hit and xlat_addr are 0, the size field (bits 4..0) of the translation register reads 0, and the inbound base register reads 0.
- R2: The translation register (reg_sel = 0) always reads bit 31 and bits 11..5 as 0. The inbound base register (reg_sel = 1) always reads bits 11..0 as 0. Writes to these bits have no effect.
- R3: While the size code is 0, no incoming address produces a hit.
- R4: Size codes 1 to 10, 30 and 31 are reserved and act like code 0: hit stays low and xlat_addr stays 0.
- R5: For a legal size code N (11 to 29), with K = N+1, a hit occurs exactly when in_valid is high and in_addr[31:K] equals the inbound base bits [31:K]. Base bits and address bits below K are ignored.
- R6: On a hit, xlat_addr[K-1:0] equals in_addr[K-1:0] and xlat_addr[30:K] equals translation base bits [30:K]. Translation base bits below K have no effect.
- R7: hit and xlat_addr are registered and appear one cycle after in_addr and in_valid are presented. Whenever hit is low, xlat_addr is 0, and that includes the cycles in which in_valid was low.
- R8: A register write made in a given cycle first applies to addresses presented in the following cycle. An address presented in the same cycle as the write still uses the old settings.
- R9: Bit 31 of xlat_addr is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | 1 | Register select: 0 = translation register, 1 = inbound base register |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| in_valid | input | 1 | Incoming address valid |
| in_addr | input | 32 | Incoming external address |
| hit | output | 1 | Registered window hit |
| xlat_addr | output | 32 | Registered translated local address, 0 when no hit |

## Verification
The assertions assume that reset is held for at least one clock edge before any traffic arrives. They also assume that reg_sel and the incoming address are known whenever they are sampled. The bench drives every input only on falling edges and holds reset across the first edges. All inputs have defined values from time zero, so no check ever sees unknown data. The stimulus covers every size code, including the reserved ones, and writes all-ones patterns to reach the reserved bits.

// File: rtl/itw_pkg.sv
`timescale 1ns/1ps
package itw_pkg;

    localparam int ITW_AW       = 32;
    localparam int ITW_CW       = 5;
    localparam int ITW_GRAN_LSB = 12;
    localparam int ITW_CODE_MIN = 11;
    localparam int ITW_CODE_MAX = 29;

    typedef enum logic [1:0] {
        CODE_OFF = 2'd0,
        CODE_RSV = 2'd1,
        CODE_OK  = 2'd2
    } itw_code_e;

    function automatic itw_code_e classify_code(input int code, input int cmin, input int cmax);
        if (code == 0)
            return CODE_OFF;
        else if (code >= cmin && code <= cmax)
            return CODE_OK;
        else
            return CODE_RSV;
    endfunction

endpackage

// File: rtl/itw_regs.sv
`timescale 1ns/1ps
module itw_regs #(
    parameter int AW       = itw_pkg::ITW_AW,
    parameter int CW       = itw_pkg::ITW_CW,
    parameter int GRAN_LSB = itw_pkg::ITW_GRAN_LSB
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic          sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic [AW-1:0] tbase,
    output logic [AW-1:0] ibase,
    output logic [CW-1:0] code
);
    localparam int PAD_W  = GRAN_LSB - CW;
    localparam int TB_W   = AW - 1 - GRAN_LSB;
    localparam int IB_W   = AW - GRAN_LSB;

    logic [TB_W-1:0] tbase_q;
    logic [IB_W-1:0] ibase_q;
    logic [CW-1:0]   code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tbase_q <= '0;
            ibase_q <= '0;
            code_q  <= '0;
        end else if (we) begin
            if (!sel) begin
                tbase_q <= wdata[AW-2:GRAN_LSB];
                code_q  <= wdata[CW-1:0];
            end else begin
                ibase_q <= wdata[AW-1:GRAN_LSB];
            end
        end
    end

    logic [AW-1:0] ctl_view;
    logic [AW-1:0] ib_view;

    generate
        if (PAD_W > 0) begin : g_pad
            assign ctl_view = {1'b0, tbase_q, {PAD_W{1'b0}}, code_q};
        end else begin : g_nopad
            assign ctl_view = {1'b0, tbase_q, code_q[GRAN_LSB-1:0]};
        end
    endgenerate

    assign ib_view = {ibase_q, {GRAN_LSB{1'b0}}};
    assign rdata   = sel ? ib_view : ctl_view;
    assign tbase   = {1'b0, tbase_q, {GRAN_LSB{1'b0}}};
    assign ibase   = ib_view;
    assign code    = code_q;
endmodule

// File: rtl/itw_decode.sv
`timescale 1ns/1ps
module itw_decode #(
    parameter int AW       = itw_pkg::ITW_AW,
    parameter int CW       = itw_pkg::ITW_CW,
    parameter int CODE_MIN = itw_pkg::ITW_CODE_MIN,
    parameter int CODE_MAX = itw_pkg::ITW_CODE_MAX
) (
    input  logic [CW-1:0] code,
    output logic          enable,
    output logic [AW-1:0] low_mask
);
    import itw_pkg::*;

    itw_code_e cls;

    always_comb begin
        cls    = classify_code(int'(code), CODE_MIN, CODE_MAX);
        enable = (cls == CODE_OK);
        for (int i = 0; i < AW; i++) begin
            low_mask[i] = enable && (i <= int'(code));
        end
    end
endmodule

// File: rtl/itw_match.sv
`timescale 1ns/1ps
module itw_match #(
    parameter int AW = itw_pkg::ITW_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic [AW-1:0] low_mask,
    input  logic [AW-1:0] tbase,
    input  logic [AW-1:0] ibase,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    output logic          hit,
    output logic [AW-1:0] xlat_addr
);
    logic          hit_n;
    logic [AW-1:0] xlat_n;
    logic          hit_q;
    logic [AW-1:0] xlat_q;

    always_comb begin
        hit_n  = in_valid && enable &&
                 ((in_addr & ~low_mask) == (ibase & ~low_mask));
        xlat_n = hit_n ? ((tbase & ~low_mask) | (in_addr & low_mask)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_q  <= 1'b0;
            xlat_q <= '0;
        end else begin
            hit_q  <= hit_n;
            xlat_q <= xlat_n;
        end
    end

    assign hit       = hit_q;
    assign xlat_addr = xlat_q;
endmodule

// File: rtl/itw_top.sv
`timescale 1ns/1ps
module itw_top #(
    parameter int AW       = itw_pkg::ITW_AW,
    parameter int CW       = itw_pkg::ITW_CW,
    parameter int GRAN_LSB = itw_pkg::ITW_GRAN_LSB,
    parameter int CODE_MIN = itw_pkg::ITW_CODE_MIN,
    parameter int CODE_MAX = itw_pkg::ITW_CODE_MAX
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          in_valid,
    input  logic [AW-1:0] in_addr,
    output logic          hit,
    output logic [AW-1:0] xlat_addr
);
    logic [AW-1:0] tbase_w;
    logic [AW-1:0] ibase_w;
    logic [CW-1:0] code_w;
    logic          enable_w;
    logic [AW-1:0] mask_w;

    itw_regs #(.AW(AW), .CW(CW), .GRAN_LSB(GRAN_LSB)) regs_i (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .tbase (tbase_w),
        .ibase (ibase_w),
        .code  (code_w)
    );

    itw_decode #(.AW(AW), .CW(CW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) dec_i (
        .code     (code_w),
        .enable   (enable_w),
        .low_mask (mask_w)
    );

    itw_match #(.AW(AW)) match_i (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable_w),
        .low_mask  (mask_w),
        .tbase     (tbase_w),
        .ibase     (ibase_w),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .hit       (hit),
        .xlat_addr (xlat_addr)
    );
endmodule

// File: rtl/itw_chk.sv
`timescale 1ns/1ps
module itw_chk #(
    parameter int AW       = itw_pkg::ITW_AW,
    parameter int CW       = itw_pkg::ITW_CW,
    parameter int CODE_MIN = itw_pkg::ITW_CODE_MIN,
    parameter int CODE_MAX = itw_pkg::ITW_CODE_MAX
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_sel,
    input logic [AW-1:0] reg_rdata,
    input logic          in_valid,
    input logic          hit,
    input logic [AW-1:0] xlat_addr,
    input logic [CW-1:0] code
);
    logic code_legal;
    assign code_legal = (int'(code) >= CODE_MIN) && (int'(code) <= CODE_MAX);

    // R2
    a_r2_rsv_read_zero: assert property (@(posedge clk) disable iff (rst)
        !reg_sel |-> (reg_rdata[AW-1] == 1'b0 && reg_rdata[11:5] == 7'd0));

    // R3
    a_r3_disabled_no_hit: assert property (@(posedge clk) disable iff (rst)
        (code == '0) |=> !hit);

    // R4
    a_r4_reserved_no_hit: assert property (@(posedge clk) disable iff (rst)
        (code != '0 && !code_legal) |=> !hit);

    // R5
    a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !hit);

    // R7
    a_r7_miss_zero_addr: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (xlat_addr == '0));

    // R9
    a_r9_top_bit_clear: assert property (@(posedge clk) disable iff (rst)
        xlat_addr[AW-1] == 1'b0);
endmodule

bind itw_top itw_chk #(.AW(AW), .CW(CW), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .in_valid  (in_valid),
    .hit       (hit),
    .xlat_addr (xlat_addr),
    .code      (code_w)
);

// File: tb/itw_top_tb_top.sv
`timescale 1ns/1ps
module itw_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        hit;
    logic [31:0] xlat_addr;

    always #5 clk = ~clk;

    itw_top dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .hit       (hit),
        .xlat_addr (xlat_addr)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [31:0] m_ctl = 32'h0;
    logic [31:0] m_ib  = 32'h0;

    logic        exp_hit_q[$];
    logic [31:0] exp_addr_q[$];
    string       exp_tag_q[$];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int win_bits(input logic [31:0] ctl);
        int c;
        c = int'(ctl[4:0]);
        if (c >= 11 && c <= 29) return c + 1;
        return -1;
    endfunction

    task automatic step(input logic we, input logic sel, input logic [31:0] wd,
                        input logic v, input logic [31:0] a, input string tag);
        int k;
        logic eh;
        logic [31:0] ea;
        logic [31:0] lowm;
        @(negedge clk);
        reg_we = we; reg_sel = sel; reg_wdata = wd; in_valid = v; in_addr = a;
        k = win_bits(m_ctl);
        eh = 1'b0; ea = 32'h0;
        if (k > 0 && v) begin
            lowm = (32'h1 << k) - 32'h1;
            eh = ((a >> k) == (m_ib >> k));
            if (eh) ea = (m_ctl & 32'h7FFF_F000 & ~lowm) | (a & lowm);
        end
        exp_hit_q.push_back(eh);
        exp_addr_q.push_back(ea);
        exp_tag_q.push_back(tag);
        if (we) begin
            if (!sel) m_ctl = wd & 32'h7FFF_F01F;
            else      m_ib  = wd & 32'hFFFF_F000;
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] wd);
        step(1'b1, sel, wd, 1'b0, 32'h0, "R7 idle write");
    endtask

    task automatic go(input logic [31:0] a, input string tag);
        step(1'b0, 1'b0, 32'h0, 1'b1, a, tag);
    endtask

    task automatic rd_check(input logic sel, input logic [31:0] exp, input string tag);
        step(1'b0, sel, 32'h0, 1'b0, 32'h0, "R7 idle read");
        #1;
        check(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_hit_q.size() > 0) begin
                logic eh;
                logic [31:0] ea;
                string t;
                eh = exp_hit_q.pop_front();
                ea = exp_addr_q.pop_front();
                t  = exp_tag_q.pop_front();
                check(hit == eh, {t, " hit"}, {31'h0, hit}, {31'h0, eh});
                check(xlat_addr == ea, {t, " addr"}, xlat_addr, ea);
                check(xlat_addr[31] == 1'b0, "R9 top bit", xlat_addr, ea);
            end
        end
    end

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            report();
        end
    end

    initial begin
        logic [31:0] lf;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(hit == 1'b0, "R1 hit after reset", {31'h0, hit}, 32'h0);
        check(xlat_addr == 32'h0, "R1 addr after reset", xlat_addr, 32'h0);
        reg_sel = 1'b0; #1;
        check(reg_rdata[4:0] == 5'd0, "R1 size code after reset", {27'h0, reg_rdata[4:0]}, 32'h0);
        reg_sel = 1'b1; #1;
        check(reg_rdata == 32'h0, "R1 inbound base after reset", reg_rdata, 32'h0);

        // R3 disabled: code 0, matching address
        go(32'h0000_0123, "R3 disabled");
        go(32'h0000_0000, "R3 disabled zero");

        // R2 reserved bits
        wr(1'b0, 32'hFFFF_FFFF);
        rd_check(1'b0, 32'h7FFF_F01F, "R2 translation reserved bits");
        wr(1'b1, 32'hFFFF_FFFF);
        rd_check(1'b1, 32'hFFFF_F000, "R2 inbound reserved bits");
        // R4 code 31 reserved
        go(32'hFFFF_FFFF, "R4 code 31");
        wr(1'b0, 32'h7FFF_F01E);
        go(32'hFFFF_F000, "R4 code 30");
        wr(1'b0, 32'h7FFF_F00A);
        go(32'hFFFF_FABC, "R4 code 10");
        wr(1'b0, 32'h7FFF_F001);
        go(32'hFFFF_F001, "R4 code 1");

        // R5 R6: 4 Kbyte window
        wr(1'b1, 32'h8000_0000);
        wr(1'b0, 32'h1234_500B);
        go(32'h8000_0ABC, "R6 4K hit");
        go(32'h8000_1ABC, "R5 4K miss");
        step(1'b0, 1'b0, 32'h0, 1'b0, 32'h8000_0ABC, "R7 valid low");
        go(32'h0000_0ABC, "R5 4K miss top");

        // R5 R6: 1 Mbyte window, unaligned base bits ignored
        wr(1'b1, 32'h9ABF_F000);
        wr(1'b0, 32'h456F_F013);
        go(32'h9AB1_2345, "R6 1M hit");
        go(32'h9AC1_2345, "R5 1M miss");

        // R9: 1 Gbyte window
        wr(1'b1, 32'hC000_0000);
        wr(1'b0, 32'h7FFF_F01D);
        go(32'hC123_4567, "R9 1G hit");
        go(32'h8123_4567, "R5 1G miss");

        // R8 write timing
        wr(1'b1, 32'h8000_0000);
        wr(1'b0, 32'h1234_500B);
        step(1'b1, 1'b0, 32'h0000_0000, 1'b1, 32'h8000_0ABC, "R8 same cycle");
        go(32'h8000_0ABC, "R8 next cycle");
        step(1'b1, 1'b0, 32'h1234_500B, 1'b1, 32'h8000_0ABC, "R8 enable same");
        go(32'h8000_0ABC, "R8 enable next");

        // sweep all codes
        lf = 32'hACE1_2468;
        for (int c = 0; c < 32; c++) begin
            wr(1'b1, lf ^ 32'h0F0F_0000);
            wr(1'b0, (lf & 32'h7FFF_F000) | c);
            for (int j = 0; j < 4; j++) begin
                lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
                go((j[0]) ? lf : ((m_ib & ~32'h00FF_FFFF) | (lf & 32'h00FF_FFFF)),
                   "R5 R6 sweep");
            end
        end

        step(1'b0, 1'b0, 32'h0, 1'b0, 32'h0, "R7 drain");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        report();
    end

endmodule